// File: doc/BRIEF.md
# Carry-Select Add/Subtract Logic Slice

This block is a slice of ten identical logic cells that share one set of control lines. Each cell owns a 16-entry lookup table and an output flip-flop. In table mode the flip-flop captures the table entry addressed by the cell's four data bits. In arithmetic mode each cell works out its sum bit and carry for both possible incoming carries in advance, and the true carry then only picks between the two. A ripple through the slice therefore passes one multiplexer per cell.

A dynamic subtract line is XORed into the first data bit of every cell. When it is high, the carry into cell 0 is forced to 1, so the slice computes a two's-complement difference. Cluster-wide synchronous clear and load lines override the cell function. A chain enable turns the ten flip-flops into a shift register that is fed from a chain input. The last carry leaves the slice unregistered so that a further slice can extend the word.

Top module: `addsub_slice`

## Requirements
- R1: While the asynchronous active-low reset is asserted, every cell register is 0, and so is `chainOut`.
- R2: When `arithMode`=0 and no override is active, cell i captures bit `lutCfg[16*i + idx]` at the next rising edge, where idx = {dataD[i], dataC[i], dataB[i], dataA[i]^addSub} with dataD as bit 3 and the inverted-or-not dataA as bit 0.
- R3: When `arithMode`=1 and `addSub`=0 and no override is active, `regOut` at the next edge equals (dataA + dataB + carryIn) mod 2^10.
- R4: When `addSub`=1, the slice uses the bitwise inverse of dataA and a forced carry-in of 1, so that arithmetic mode captures (dataB - dataA) mod 2^10 whatever the value of `carryIn`.
- R5: `carryOut` is combinational and is valid in the same cycle as its inputs. It equals bit 10 of dataA' + dataB + cin', where dataA' and cin' are the effective operand and carry of R3/R4. In subtract mode it is 1 exactly when dataB >= dataA.
- R6: When `syncLoad`=1 and `syncClear`=0, every cell captures its dataD bit at the next edge.
- R7: When `chainEn`=1 and neither clear nor load is active, cell 0 captures `chainIn` and cell i captures the old value of cell i-1. `chainOut` always equals the register of cell 9.
- R8: Priority is clear over load, load over chain shift, and chain shift over the table/arithmetic result. `syncClear`=1 gives all zeros at the next edge whatever the other controls are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lutCfg | input | 160 | Static table contents, 16 bits per cell, cell 0 in the low bits |
| dataA | input | 10 | First data bit of each cell, XORed with addSub |
| dataB | input | 10 | Second data bit of each cell |
| dataC | input | 10 | Third data bit of each cell (table address only) |
| dataD | input | 10 | Fourth data bit of each cell, also the load value |
| arithMode | input | 1 | 1 selects the arithmetic sum, 0 selects the table output |
| addSub | input | 1 | 1 selects subtraction |
| carryIn | input | 1 | Slice carry-in used when adding |
| syncLoad | input | 1 | Synchronous load of dataD |
| syncClear | input | 1 | Synchronous clear |
| chainEn | input | 1 | Shift the registers along the chain |
| chainIn | input | 1 | Serial input into cell 0 |
| regOut | output | 10 | Registered cell outputs |
| carryOut | output | 1 | Unregistered carry out of cell 9 |
| chainOut | output | 1 | Register of cell 9, for the next slice's chain |

## Verification
The bench runs carries that ripple through all ten cells, such as 0x3FF + 1 with and without carry-in. A design with a wrong carry selection would show a wrong sum bit or a stuck carryOut here. Subtraction is tried with equal operands, with dataB smaller than dataA, and with carryIn held at both values. A slice that fails to force the carry would be off by one, and one that inverts the wrong operand would give the negated result. The bench drives every pair of controls together, so a swapped priority would let a load beat a clear or a shift beat a load. The table mode uses a different pattern in each cell and is also run with the subtract line high, which exposes a table address taken from the wrong bits or missing its inverted first bit.

// File: rtl/ls_pkg.sv
package ls_pkg;
  // Resolved per-cycle strobes from the control to the datapath
  typedef struct packed {
    logic clr;
    logic ld;
    logic shift;
    logic arith;
    logic sub;
    logic cin;
  } ls_strobe_t;
endpackage

// File: rtl/ls_ctrl.sv
module ls_ctrl
  import ls_pkg::*;
(
  input  logic       syncClear,
  input  logic       syncLoad,
  input  logic       chainEn,
  input  logic       arithMode,
  input  logic       addSub,
  input  logic       carryIn,
  output ls_strobe_t strobe
);
  always_comb begin
    strobe.clr   = syncClear;
    strobe.ld    = syncLoad & ~syncClear;
    strobe.shift = chainEn & ~syncLoad & ~syncClear;
    strobe.arith = arithMode;
    strobe.sub   = addSub;
    // subtraction needs +1 after inverting the operand
    strobe.cin   = addSub ? 1'b1 : carryIn;
  end

  always_comb begin
    assert ($onehot0({strobe.clr, strobe.ld, strobe.shift}))
      else $error("AST_ONE_OVERRIDE violated"); // R8
  end
endmodule

// File: rtl/ls_cell.sv
module ls_cell
  import ls_pkg::*;
#(
  parameter int LUT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LUT_W-1:0] lutMask,
  input  logic             a,
  input  logic             b,
  input  logic             c,
  input  logic             d,
  input  logic             cIn,
  input  logic             prevQ,
  input  ls_strobe_t       strobe,
  output logic             cOut,
  output logic             q
);
  logic aEff, prop;
  logic sum0, sum1, car0, car1;
  logic lutOut, sumSel, nextQ;

  always_comb begin
    aEff   = a ^ strobe.sub;
    lutOut = lutMask[{d, c, b, aEff}];
    prop   = aEff ^ b;
    // both outcomes prepared ahead of the incoming carry
    sum0   = prop;
    sum1   = ~prop;
    car0   = aEff & b;
    car1   = aEff | b;
    sumSel = cIn ? sum1 : sum0;
    cOut   = cIn ? car1 : car0;
  end

  always_comb begin
    if (strobe.clr)        nextQ = 1'b0;
    else if (strobe.ld)    nextQ = d;
    else if (strobe.shift) nextQ = prevQ;
    else if (strobe.arith) nextQ = sumSel;
    else                   nextQ = lutOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= 1'b0;
    else       q <= nextQ;
  end
endmodule

// File: rtl/ls_datapath.sv
module ls_datapath
  import ls_pkg::*;
#(
  parameter int CELLS = 10,
  parameter int LUT_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [CELLS*LUT_W-1:0] lutCfg,
  input  logic [CELLS-1:0]       dataA,
  input  logic [CELLS-1:0]       dataB,
  input  logic [CELLS-1:0]       dataC,
  input  logic [CELLS-1:0]       dataD,
  input  logic                   chainIn,
  input  ls_strobe_t             strobe,
  output logic [CELLS-1:0]       regOut,
  output logic                   carryOut
);
  logic [CELLS:0]   carry;
  logic [CELLS-1:0] prevQ;

  assign carry[0] = strobe.cin;
  assign prevQ    = {regOut[CELLS-2:0], chainIn};
  assign carryOut = carry[CELLS];

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    ls_cell #(.LUT_W(LUT_W)) u_cell (
      .clk    (clk),
      .rstN   (rstN),
      .lutMask(lutCfg[i*LUT_W +: LUT_W]),
      .a      (dataA[i]),
      .b      (dataB[i]),
      .c      (dataC[i]),
      .d      (dataD[i]),
      .cIn    (carry[i]),
      .prevQ  (prevQ[i]),
      .strobe (strobe),
      .cOut   (carry[i+1]),
      .q      (regOut[i])
    );
  end

  // arithmetic reference for the checks only
  logic [CELLS:0] refSum;
  assign refSum = {1'b0, dataA ^ {CELLS{strobe.sub}}} + {1'b0, dataB} + {{CELLS{1'b0}}, strobe.cin};

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> regOut == '0) else $error("AST_CLEAR_WINS"); // R8
  AST_LOAD_D: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ld |=> regOut == $past(dataD)) else $error("AST_LOAD_D"); // R6
  AST_SHIFT_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> regOut == {$past(regOut[CELLS-2:0]), $past(chainIn)}) else $error("AST_SHIFT_CHAIN"); // R7
  AST_ARITH_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.arith && !strobe.clr && !strobe.ld && !strobe.shift) |=> regOut == $past(refSum[CELLS-1:0]))
    else $error("AST_ARITH_SUM"); // R3
  AST_CARRY_OUT: assert property (@(posedge clk) disable iff (!rstN)
    carryOut == refSum[CELLS]) else $error("AST_CARRY_OUT"); // R5
  AST_SUB_EQUAL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sub && dataA == dataB) |-> carryOut) else $error("AST_SUB_EQUAL"); // R4
endmodule

// File: rtl/addsub_slice.sv
module addsub_slice
  import ls_pkg::*;
#(
  parameter int CELLS = 10,
  parameter int LUT_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [CELLS*LUT_W-1:0] lutCfg,
  input  logic [CELLS-1:0]       dataA,
  input  logic [CELLS-1:0]       dataB,
  input  logic [CELLS-1:0]       dataC,
  input  logic [CELLS-1:0]       dataD,
  input  logic                   arithMode,
  input  logic                   addSub,
  input  logic                   carryIn,
  input  logic                   syncLoad,
  input  logic                   syncClear,
  input  logic                   chainEn,
  input  logic                   chainIn,
  output logic [CELLS-1:0]       regOut,
  output logic                   carryOut,
  output logic                   chainOut
);
  ls_strobe_t strobe;

  ls_ctrl u_ctrl (
    .syncClear(syncClear),
    .syncLoad (syncLoad),
    .chainEn  (chainEn),
    .arithMode(arithMode),
    .addSub   (addSub),
    .carryIn  (carryIn),
    .strobe   (strobe)
  );

  ls_datapath #(.CELLS(CELLS), .LUT_W(LUT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .lutCfg  (lutCfg),
    .dataA   (dataA),
    .dataB   (dataB),
    .dataC   (dataC),
    .dataD   (dataD),
    .chainIn (chainIn),
    .strobe  (strobe),
    .regOut  (regOut),
    .carryOut(carryOut)
  );

  assign chainOut = regOut[CELLS-1];

  AST_RESET_ZERO: assert property (@(posedge clk) !rstN |-> regOut == '0)
    else $error("AST_RESET_ZERO"); // R1
endmodule

// File: tb/tb_addsub_slice.sv
module tb_addsub_slice;
  localparam int N = 10;
  localparam int W = 16;

  logic clk = 0, rstN = 0;
  logic [N*W-1:0] lutCfg;
  logic [N-1:0] dataA, dataB, dataC, dataD, regOut;
  logic arithMode, addSub, carryIn, syncLoad, syncClear, chainEn, chainIn;
  logic carryOut, chainOut;
  int nRun = 0, nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  addsub_slice dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    arithMode = 0; addSub = 0; carryIn = 0; syncLoad = 0;
    syncClear = 0; chainEn = 0; chainIn = 0;
    dataA = 0; dataB = 0; dataC = 0; dataD = 0;
  endtask

  // step: inputs already set before a negedge; wait for capture edge
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R1 regOut", regOut, 0);
    chk("R1 chainOut", chainOut, 0);
  endtask

  function automatic logic [N-1:0] lutExp(logic sub);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++)
      r[i] = lutCfg[i*W + {dataD[i], dataC[i], dataB[i], dataA[i] ^ sub}];
    return r;
  endfunction

  task automatic t_lut();
    @(negedge clk); idle();
    dataA = 10'h155; dataB = 10'h0F3; dataC = 10'h2A9; dataD = 10'h3C4;
    step(); chk("R2 lut add", regOut, lutExp(0));
    @(negedge clk); dataA = 10'h0E1; dataB = 10'h31C; dataC = 10'h1B6; dataD = 10'h07A;
    step(); chk("R2 lut pattern2", regOut, lutExp(0));
    @(negedge clk); addSub = 1;
    step(); chk("R2 lut subtract inverts A", regOut, lutExp(1));
  endtask

  task automatic t_add(logic [N-1:0] a, logic [N-1:0] b, logic ci);
    logic [N:0] s;
    @(negedge clk); idle(); arithMode = 1;
    dataA = a; dataB = b; carryIn = ci;
    s = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, ci};
    #1 chk("R5 carryOut add", carryOut, s[N]);
    step(); chk("R3 add sum", regOut, s[N-1:0]);
  endtask

  task automatic t_sub(logic [N-1:0] a, logic [N-1:0] b, logic ci);
    logic [N-1:0] d;
    @(negedge clk); idle(); arithMode = 1; addSub = 1;
    dataA = a; dataB = b; carryIn = ci;
    d = b - a;
    #1 chk("R5 carryOut no-borrow", carryOut, (b >= a) ? 1 : 0);
    step(); chk("R4 sub diff", regOut, d);
  endtask

  task automatic t_load();
    @(negedge clk); idle(); syncLoad = 1; arithMode = 1;
    dataA = 10'h3FF; dataB = 10'h001; dataD = 10'h2B5;
    step(); chk("R6 load", regOut, 10'h2B5);
    chk("R7 chainOut tracks cell9", chainOut, 1);
  endtask

  task automatic t_shift();
    logic [N-1:0] e;
    logic bits [4] = '{1, 0, 1, 1};
    @(negedge clk); idle(); syncLoad = 1; dataD = 10'h301;
    step();
    e = 10'h301;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); idle(); chainEn = 1; chainIn = bits[k]; arithMode = 1;
      dataA = 10'h155; dataB = 10'h0AA;
      e = {e[N-2:0], bits[k]};
      step(); chk("R7 shift", regOut, e);
      chk("R7 chainOut", chainOut, e[N-1]);
    end
  endtask

  task automatic t_priority();
    @(negedge clk); idle(); syncLoad = 1; dataD = 10'h3FF;
    step();
    @(negedge clk); syncClear = 1; syncLoad = 1; chainEn = 1; chainIn = 1; dataD = 10'h155;
    step(); chk("R8 clear beats load", regOut, 0);
    @(negedge clk); idle(); syncLoad = 1; chainEn = 1; chainIn = 1; dataD = 10'h0F0;
    step(); chk("R8 load beats shift", regOut, 10'h0F0);
    @(negedge clk); idle(); chainEn = 1; chainIn = 0; arithMode = 1; dataA = 10'h3FF; dataB = 10'h3FF;
    step(); chk("R8 shift beats arith", regOut, 10'h1E0);
    @(negedge clk); idle(); syncClear = 1; arithMode = 1; dataA = 10'h123; dataB = 10'h0FF;
    step(); chk("R8 clear beats arith", regOut, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++)
      lutCfg[i*W +: W] = 16'hA5C3 ^ (16'h1357 * (i + 1));
    idle();
    #1 t_reset();
    #9 @(negedge clk); rstN = 1;
    t_lut();
    t_add(10'h3FF, 10'h000, 1);
    t_add(10'h3FF, 10'h001, 0);
    t_add(10'h155, 10'h0AA, 0);
    t_add(10'h123, 10'h0FE, 1);
    t_sub(10'h0C8, 10'h0C8, 0);
    t_sub(10'h200, 10'h0FF, 0);
    t_sub(10'h005, 10'h300, 1);
    t_sub(10'h300, 10'h005, 1);
    t_load();
    t_shift();
    t_priority();
    @(negedge clk); rstN = 0; #1 t_reset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule